// File: doc/BRIEF.md
# Microcode Vector Sequencer

This block covers the decode path for work that the fast hardware decoders do not handle: complex instructions, serializing conditions, interrupts and exceptions. When a vector decode is presented, the hardware supplies a ready-made first group of four micro-ops and a starting address in an internal micro-op ROM. The sequencer sends that first group downstream. It then reads further four-op groups from the ROM, one address after another, and stops after the entry whose end flag is set.

Every group leaves through one valid/ready output. Groups from hardware and groups from the ROM use the same eight-bit operation format. Unused slots hold NOPs. While a sequence runs, `busy` holds off the other decode paths, and no new vector or interrupt is accepted. An interrupt request seen while the block is idle starts a ROM sequence at a fixed vector address. That sequence has no hardware-built first group. A small computed ROM holds a few example sequences in place of real microcode.

Top module: `ucode_vector_seq`

## Requirements
- R1: After a synchronous reset, `busy` and `out_valid` are 0 and `out_last` is 0.
- R2: When `vec_valid` and `vec_ready` are both 1 at a clock edge, the next cycle shows `out_valid`=1 with `out_group` equal to the accepted `vec_group`. After that group is taken, the ROM entry at `vec_addr` is emitted.
- R3: Each group is four 8-bit ops, with slot i at bits [8i+7:8i]. An op is {kind[2:0], arg[4:0]}, where kind 0=NOP, 1=ALU, 2=LOAD, 3=STORE, 4=BRANCH. A ROM entry at address a holds n ops of one kind, with slot i<n carrying arg (4a+i) mod 32, and NOP (all zero) in the rest. The entries are: a=2 ALU n=4, a=3 LOAD n=2 end, a=5 STORE n=3 end, a=8 ALU n=4, a=9 BRANCH n=1, a=10 ALU n=3 end. Every other address holds four NOPs with the end flag set.
- R4: After a ROM group is taken, the next address is the current one plus one. `out_last` is 1 exactly while a ROM group with the end flag is shown. Once that group is taken, the block is idle on the next cycle.
- R5: While `out_valid`=1 and `out_ready`=0, the next cycle shows the same group with `out_valid` still 1.
- R6: `busy` is 1 from the cycle after acceptance until the last group is taken. While `busy` is 1, `vec_ready` and `irq_ack` are 0.
- R7: An `irq_req` seen while the block is idle is acknowledged in that cycle by `irq_ack`. The next cycle shows the ROM group at address 8, with no hardware group before it.
- R8: If `irq_req` and `vec_valid` are both 1 in an idle cycle, the interrupt is taken and `vec_ready` is 0, so the vector decode is not accepted.
- R9: An `irq_req` held high during a running sequence has no effect until the sequence ends. It is then accepted in the first idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vec_valid | input | 1 | Vector decode presented |
| vec_ready | output | 1 | Vector decode would be accepted this cycle |
| vec_group | input | 32 | Hardware-built first group |
| vec_addr | input | 4 | ROM start address of the continuation |
| irq_req | input | 1 | Interrupt request at an instruction boundary |
| irq_ack | output | 1 | Interrupt accepted this cycle |
| out_valid | output | 1 | Output group valid |
| out_ready | input | 1 | Downstream accepts the group |
| out_group | output | 32 | Four-op group |
| out_last | output | 1 | Shown group ends the sequence |
| busy | output | 1 | Sequence in progress; other decode paths held off |

## Verification
In an idle cycle, an interrupt start and a vector-decode acceptance can fall in the same cycle. The bench provokes this by raising `irq_req` and `vec_valid` together. It expects `irq_ack` high, `vec_ready` low, and the address-8 stream without any hardware group. A second case holds the interrupt high through a running vector sequence. The expected result is that nothing changes until the end group is taken, and that the interrupt sequence starts in the very next idle cycle. A behavioural queue model predicts every output on every cycle, including cycles where downstream stalls.

// File: rtl/uvs_pkg.sv
package uvs_pkg;

    localparam int OP_W    = 8;
    localparam int SLOTS   = 4;
    localparam int GROUP_W = OP_W * SLOTS;

    typedef enum logic [2:0] {
        K_NOP    = 3'd0,
        K_ALU    = 3'd1,
        K_LOAD   = 3'd2,
        K_STORE  = 3'd3,
        K_BRANCH = 3'd4
    } op_kind_e;

    typedef struct packed {
        op_kind_e   kind;
        logic [4:0] arg;
    } uop_t;

    typedef struct packed {
        logic               last;
        logic [GROUP_W-1:0] ops;
    } rom_word_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HW   = 2'd1,
        S_ROM  = 2'd2
    } seq_state_e;

    function automatic logic [GROUP_W-1:0] make_group(op_kind_e k, int n, int base);
        logic [GROUP_W-1:0] g;
        uop_t               u;
        g = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (i < n) begin
                u.kind = k;
                u.arg  = 5'((base + i) % 32);
            end else begin
                u = '0;
            end
            g[i*OP_W +: OP_W] = u;
        end
        return g;
    endfunction

    function automatic rom_word_t rom_lookup(int a);
        rom_word_t w;
        case (a)
            2:       w = '{last: 1'b0, ops: make_group(K_ALU,    4, a * 4)};
            3:       w = '{last: 1'b1, ops: make_group(K_LOAD,   2, a * 4)};
            5:       w = '{last: 1'b1, ops: make_group(K_STORE,  3, a * 4)};
            8:       w = '{last: 1'b0, ops: make_group(K_ALU,    4, a * 4)};
            9:       w = '{last: 1'b0, ops: make_group(K_BRANCH, 1, a * 4)};
            10:      w = '{last: 1'b1, ops: make_group(K_ALU,    3, a * 4)};
            default: w = '{last: 1'b1, ops: '0};
        endcase
        return w;
    endfunction

endpackage

// File: rtl/uvs_rom.sv
module uvs_rom
    import uvs_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output rom_word_t         word
);
    localparam int DEPTH = 1 << ADDR_W;

    rom_word_t table_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        assign table_q[g] = rom_lookup(g);
    end

    assign word = table_q[addr];
endmodule

// File: rtl/uvs_ctrl.sv
module uvs_ctrl
    import uvs_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int IRQ_VEC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vec_valid,
    input  logic [ADDR_W-1:0] vec_addr,
    input  logic              irq_req,
    input  logic              out_ready,
    input  logic              rom_last,
    output seq_state_e        state_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              vec_ready_o,
    output logic              vec_take_o,
    output logic              irq_take_o
);
    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              idle;

    assign idle        = (state_q == S_IDLE);
    assign irq_take_o  = idle && irq_req;
    assign vec_ready_o = idle && !irq_req;
    assign vec_take_o  = vec_ready_o && vec_valid;
    assign state_o     = state_q;
    assign addr_o      = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (irq_take_o) begin
                        state_q <= S_ROM;
                        addr_q  <= ADDR_W'(IRQ_VEC);
                    end else if (vec_take_o) begin
                        state_q <= S_HW;
                        addr_q  <= vec_addr;
                    end
                end
                S_HW: begin
                    if (out_ready) state_q <= S_ROM;
                end
                S_ROM: begin
                    if (out_ready) begin
                        if (rom_last) state_q <= S_IDLE;
                        else          addr_q  <= addr_q + 1'b1;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assert_irq_start_R7: assert property (@(posedge clk) disable iff (rst)
        irq_take_o |=> (state_q == S_ROM && addr_q == ADDR_W'(IRQ_VEC)));

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_ROM && out_ready && !rom_last) |=> (addr_q == $past(addr_q) + 1'b1));
endmodule

// File: rtl/ucode_vector_seq.sv
module ucode_vector_seq
    import uvs_pkg::*;
#(
    parameter int ADDR_W  = 4,
    parameter int IRQ_VEC = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                vec_valid,
    output logic                vec_ready,
    input  logic [GROUP_W-1:0]  vec_group,
    input  logic [ADDR_W-1:0]   vec_addr,
    input  logic                irq_req,
    output logic                irq_ack,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [GROUP_W-1:0]  out_group,
    output logic                out_last,
    output logic                busy
);
    seq_state_e         state;
    logic [ADDR_W-1:0]  addr;
    logic               vec_take;
    rom_word_t          rom_word;
    logic [GROUP_W-1:0] first_q;

    uvs_ctrl #(.ADDR_W(ADDR_W), .IRQ_VEC(IRQ_VEC)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .vec_valid   (vec_valid),
        .vec_addr    (vec_addr),
        .irq_req     (irq_req),
        .out_ready   (out_ready),
        .rom_last    (rom_word.last),
        .state_o     (state),
        .addr_o      (addr),
        .vec_ready_o (vec_ready),
        .vec_take_o  (vec_take),
        .irq_take_o  (irq_ack)
    );

    uvs_rom #(.ADDR_W(ADDR_W)) u_rom (
        .addr (addr),
        .word (rom_word)
    );

    always_ff @(posedge clk) begin
        if (rst)           first_q <= '0;
        else if (vec_take) first_q <= vec_group;
    end

    assign busy      = (state != S_IDLE);
    assign out_valid = busy;
    assign out_group = (state == S_HW) ? first_q : rom_word.ops;
    assign out_last  = (state == S_ROM) && rom_word.last;

    assert_reset_R1: assert property (@(posedge clk) rst |=> (!busy && !out_valid));

    assert_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && vec_ready) |=> (out_valid && out_group == $past(vec_group)));

    assert_end_idle_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ready && out_last) |=> !busy);

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_group)));

    assert_busy_block_R6: assert property (@(posedge clk) disable iff (rst)
        busy |-> (!vec_ready && !irq_ack));

    assert_irq_wins_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_req && vec_valid && !busy) |=> (out_valid && $past(irq_ack)));
endmodule

// File: tb/ucode_vector_seq_bench.sv
module ucode_vector_seq_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        vec_valid;
    logic        vec_ready;
    logic [31:0] vec_group;
    logic [3:0]  vec_addr;
    logic        irq_req;
    logic        irq_ack;
    logic        out_valid;
    logic        out_ready;
    logic [31:0] out_group;
    logic        out_last;
    logic        busy;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    string cur_req = "R2";

    typedef struct {
        logic [31:0] g;
        bit          last;
    } ent_t;
    ent_t q[$];

    always #5 clk = ~clk;

    ucode_vector_seq u_ucode_vector_seq (
        .clk(clk), .rst(rst), .vec_valid(vec_valid), .vec_ready(vec_ready),
        .vec_group(vec_group), .vec_addr(vec_addr), .irq_req(irq_req),
        .irq_ack(irq_ack), .out_valid(out_valid), .out_ready(out_ready),
        .out_group(out_group), .out_last(out_last), .busy(busy)
    );

    function automatic void tbl(input int a, output logic [31:0] g, output bit last);
        int k = 0;
        int n = 0;
        last = 1;
        if      (a == 2)  begin k = 1; n = 4; last = 0; end
        else if (a == 3)  begin k = 2; n = 2; end
        else if (a == 5)  begin k = 3; n = 3; end
        else if (a == 8)  begin k = 1; n = 4; last = 0; end
        else if (a == 9)  begin k = 4; n = 1; last = 0; end
        else if (a == 10) begin k = 1; n = 3; end
        g = '0;
        for (int i = 0; i < n; i++) g[i*8 +: 8] = {3'(k), 5'((a * 4 + i) % 32)};
    endfunction

    task automatic push_rom(input int start);
        int   a = start;
        ent_t e;
        forever begin
            tbl(a, e.g, e.last);
            q.push_back(e);
            if (e.last) break;
            a = (a + 1) % 16;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (rst) q.delete();
        else if (q.size() != 0) begin
            if (out_ready) void'(q.pop_front());
        end else if (irq_req) begin
            push_rom(8);
        end else if (vec_valid) begin
            ent_t e;
            e.g = vec_group; e.last = 0;
            q.push_back(e);
            push_rom(int'(vec_addr));
        end
    end

    task automatic check(input bit ok, input string req, input string nm,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, nm, act, exp);
        end
    endtask

    task automatic compare();
        bit          e_busy  = (q.size() != 0);
        logic [31:0] e_group = e_busy ? q[0].g : 32'h0;
        bit          e_last  = e_busy ? q[0].last : 1'b0;
        check(busy == e_busy, "R6", "busy", 32'(busy), 32'(e_busy));
        check(out_valid == e_busy, cur_req, "out_valid", 32'(out_valid), 32'(e_busy));
        check(vec_ready == (!e_busy && !irq_req), "R8", "vec_ready",
              32'(vec_ready), 32'(!e_busy && !irq_req));
        check(irq_ack == (!e_busy && irq_req), "R7", "irq_ack",
              32'(irq_ack), 32'(!e_busy && irq_req));
        if (e_busy) begin
            check(out_group == e_group, cur_req, "out_group", out_group, e_group);
            check(out_last == e_last, "R4", "out_last", 32'(out_last), 32'(e_last));
        end
    endtask

    task automatic cyc(input bit vv, input int va, input logic [31:0] vg,
                       input bit irq, input bit rdy);
        @(negedge clk);
        vec_valid = vv; vec_addr = 4'(va); vec_group = vg;
        irq_req = irq; out_ready = rdy;
        #1 compare();
    endtask

    initial begin
        rst = 1'b1; vec_valid = 0; vec_addr = 0; vec_group = 0;
        irq_req = 0; out_ready = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check(!busy && !out_valid && !out_last, "R1", "reset_idle",
              {29'd0, busy, out_valid, out_last}, 32'h0);

        // R2 R3 R4: hardware group then entries 2 and 3
        cur_req = "R2";
        cyc(1, 2, 32'hA1B2C3D4, 0, 1);
        for (int k = 0; k < 6; k++) cyc(0, 0, 0, 0, 1);

        // R5: stalls on sequence at 5
        cur_req = "R5";
        cyc(1, 5, 32'h11223344, 0, 1);
        for (int k = 0; k < 10; k++) cyc(0, 0, 0, 0, (k % 3) == 2);

        // R7: interrupt alone starts at 8
        cur_req = "R7";
        cyc(0, 0, 0, 1, 1);
        for (int k = 0; k < 6; k++) cyc(0, 0, 0, 0, 1);

        // R8: interrupt and vector decode together
        cur_req = "R8";
        cyc(1, 2, 32'hDEADBEEF, 1, 1);
        for (int k = 0; k < 6; k++) cyc(0, 0, 0, 0, 1);

        // R9: interrupt held during a running vector sequence
        cur_req = "R9";
        cyc(1, 2, 32'h55AA55AA, 0, 1);
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 1, 1);
        for (int k = 0; k < 8; k++) cyc(0, 0, 0, 0, k != 1);

        // R3: default entries hold one NOP group with end flag
        cur_req = "R3";
        cyc(1, 12, 32'h0F0F0F0F, 0, 1);
        for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 1);
        cyc(1, 15, 32'h76543210, 0, 0);
        for (int k = 0; k < 6; k++) cyc(0, 0, 0, 0, k > 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cycles > 100000);
        bad++;
        total++;
        $display("FAIL watchdog act=%0d exp=<100000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule